// File: doc/BRIEF.md
# Single-Transfer Bus-Master DMA Engine

This block lets a local processor move one 16-bit word between itself and host memory without copying the word by hand. The processor first fills in the transfer setup. This covers a 16-bit low address, a 4-bit upper address nibble held in one of four small slots, and, for an output transfer, the outgoing word. A write to the control register then starts the engine. The engine requests the host bus and waits for a grant. It drives the address for one cycle, then waits for the host reply. The rising edge of the reply withdraws the request, so only one transfer occurs. The falling edge of the reply ends the transfer and clears the busy flag.

There are two protections. After an output transfer finishes, a short hold-off window keeps the outgoing word frozen. A watchdog aborts any transfer that stays busy longer than the allowed time, and sets a sticky error flag. The sequencer has five states: ST_IDLE, ST_REQ, ST_ADDR, ST_DATA and ST_TAIL. The transitions are:
- *start*: ST_IDLE to ST_REQ.
- *granted*: ST_REQ to ST_ADDR, when the grant input is sampled high.
- *addressed*: ST_ADDR to ST_DATA, unconditionally.
- *reply_rise*: ST_DATA to ST_TAIL.
- *reply_fall*: ST_TAIL to ST_IDLE.
- *abort*: any busy state to ST_IDLE, when the watchdog expires.

Top module: `xfer_engine`

## Requirements
- R1: After reset, busy, bus_req, addr_valid, holdoff and err are all 0.
- R2: A write with cpu_sel=3 and cpu_wdata[6]=0, made while idle, starts a transfer: busy and bus_req are 1 in the following cycle. cpu_wdata[0] selects the direction (1 = output to host, 0 = input from host). A control write with cpu_wdata[6]=1 starts nothing.
- R3: The processor writes registers through cpu_sel:
  - 0: output low address.
  - 1: input low address.
  - 2: outgoing word.
  - 4: output upper-nibble slot.
  - 5: input upper-nibble slot.
  
  A slot write puts cpu_wdata[3:0] into the slot indexed by cpu_wdata[5:4]. At start, bus_addr is latched as {slot[cpu_wdata[5:4]], low address}, using the banks for the chosen direction.
- R4: bus_req stays 1 until bus_grant is sampled high. The next cycle is the address phase: addr_valid=1 for exactly one cycle, with bus_req still 1.
- R5: The cycle after the host reply rises during the data phase, bus_req is 0 and remains 0 for the rest of the transfer.
- R6: busy stays 1 while the reply is high. It drops in the cycle after the reply is sampled low.
- R7: On an input transfer, bus_rdata is captured at the reply's rising edge and is on data_in when busy drops.
- R8: After an output transfer completes, holdoff is 1 for HOLD_CYC cycles (1 by default). Writes to the outgoing word are ignored during that window and while an output transfer is busy.
- R9: If a transfer is busy for TMO_CYC cycles (80 by default), it is aborted. busy and bus_req drop, and err becomes 1.
- R10: err stays set until a control write with cpu_wdata[6]=1 and cpu_wdata[3]=1.
- R11: A control write made while busy is ignored. Direction, address and watchdog timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset |
| cpu_we | input | 1 | Processor register write strobe |
| cpu_sel | input | 3 | Register select |
| cpu_wdata | input | 16 | Processor write data |
| bus_grant | input | 1 | Host bus grant |
| bus_reply | input | 1 | Host reply |
| bus_rdata | input | 16 | Host read data |
| bus_req | output | 1 | Host bus request |
| addr_valid | output | 1 | Address phase strobe |
| bus_addr | output | 20 | Latched transfer address |
| bus_dir_out | output | 1 | 1 for output transfer |
| bus_wdata | output | 16 | Outgoing word |
| data_in | output | 16 | Captured incoming word |
| busy | output | 1 | Transfer in progress |
| holdoff | output | 1 | Outgoing word frozen |
| err | output | 1 | Sticky abort flag |

## Verification
The sequencer's state is visible one cycle after each event through busy, bus_req and addr_valid.
- A wrong state is seen as a request that persists past the reply edge, or an address strobe lasting more than one cycle.
- A stuck watchdog counter shows up exactly TMO_CYC cycles after a start, as busy dropping too early or too late.
- A broken hold-off shows up on bus_wdata in the cycle after a blocked write.

Edge detection on the reply is the most fragile part. A fault there appears as busy failing to fall one cycle after the reply falls.

// File: rtl/xe_pkg.sv
package xe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_TAIL
    } xe_state_t;

    localparam logic [2:0] SEL_OADDR = 3'd0;
    localparam logic [2:0] SEL_IADDR = 3'd1;
    localparam logic [2:0] SEL_DOUT  = 3'd2;
    localparam logic [2:0] SEL_CTRL  = 3'd3;
    localparam logic [2:0] SEL_OEXT  = 3'd4;
    localparam logic [2:0] SEL_IEXT  = 3'd5;

    localparam int CTL_DIR_BIT   = 0;
    localparam int CTL_CLR_BIT   = 3;
    localparam int CTL_SLOT_LSB  = 4;
    localparam int CTL_NOGO_BIT  = 6;
endpackage

// File: rtl/xe_regs.sv
module xe_regs
    import xe_pkg::*;
#(
    parameter int DW    = 16,
    parameter int XW    = 4,
    parameter int SLOTS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [2:0]                sel,
    input  logic [DW-1:0]             wdata,
    input  logic                      dout_lock,
    input  logic                      cap,
    input  logic [DW-1:0]             rdata,
    input  logic [$clog2(SLOTS)-1:0]  slot_sel,
    output logic [DW+XW-1:0]          out_addr,
    output logic [DW+XW-1:0]          in_addr,
    output logic [DW-1:0]             dout,
    output logic [DW-1:0]             din
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic [DW-1:0] oaddr_lo, iaddr_lo;
    logic [XW-1:0] ext [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oaddr_lo <= '0;
            iaddr_lo <= '0;
            dout     <= '0;
            din      <= '0;
        end else begin
            if (we && sel == SEL_OADDR) oaddr_lo <= wdata;
            if (we && sel == SEL_IADDR) iaddr_lo <= wdata;
            if (we && sel == SEL_DOUT && !dout_lock) dout <= wdata;
            if (cap) din <= rdata;
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic [2:0] BSEL = (b == 0) ? SEL_OEXT : SEL_IEXT;
        logic [XW-1:0] mem [SLOTS];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
            end else if (we && sel == BSEL) begin
                mem[wdata[XW+SLOT_W-1:XW]] <= wdata[XW-1:0];
            end
        end
        assign ext[b] = mem[slot_sel];
    end

    assign out_addr = {ext[0], oaddr_lo};
    assign in_addr  = {ext[1], iaddr_lo};
endmodule

// File: rtl/xe_seq.sv
module xe_seq
    import xe_pkg::*;
#(
    parameter int AW       = 20,
    parameter int TMO_CYC  = 80,
    parameter int HOLD_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          err_clr,
    input  logic          dir_in,
    input  logic [AW-1:0] addr_in,
    input  logic          bus_grant,
    input  logic          bus_reply,
    output logic          bus_req,
    output logic          addr_valid,
    output logic          busy,
    output logic          holdoff,
    output logic          err,
    output logic          cap,
    output logic          dir_q,
    output logic [AW-1:0] addr_q
);
    localparam int WD_W   = $clog2(TMO_CYC + 1);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    xe_state_t       st, st_nx;
    logic [WD_W-1:0]   wd;
    logic [HOLD_W-1:0] hold;
    logic              reply_q, rise, done, abort;

    assign rise  = bus_reply && !reply_q;
    assign done  = (st == ST_TAIL) && !bus_reply;
    assign abort = (st != ST_IDLE) && !done && (wd == WD_W'(TMO_CYC - 1));

    always_comb begin
        st_nx = st;
        if (abort) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (start)     st_nx = ST_REQ;
                ST_REQ:  if (bus_grant) st_nx = ST_ADDR;
                ST_ADDR:                st_nx = ST_DATA;
                ST_DATA: if (rise)      st_nx = ST_TAIL;
                ST_TAIL: if (!bus_reply) st_nx = ST_IDLE;
                default:                st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            wd      <= '0;
            hold    <= '0;
            err     <= 1'b0;
            dir_q   <= 1'b0;
            addr_q  <= '0;
            reply_q <= 1'b0;
        end else begin
            st      <= st_nx;
            reply_q <= bus_reply;
            if (hold != '0) hold <= hold - 1'b1;
            if (st == ST_IDLE && start) begin
                wd     <= '0;
                dir_q  <= dir_in;
                addr_q <= addr_in;
            end else if (st != ST_IDLE) begin
                wd <= wd + 1'b1;
            end
            if (done && dir_q) hold <= HOLD_W'(HOLD_CYC);
            if (abort)        err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    always_comb begin
        busy       = (st != ST_IDLE);
        bus_req    = (st == ST_REQ) || (st == ST_ADDR) || (st == ST_DATA);
        addr_valid = (st == ST_ADDR);
        cap        = (st == ST_DATA) && rise && !dir_q;
        holdoff    = (hold != '0);
    end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xe_pkg::*;
#(
    parameter int DW      = 16,
    parameter int XW      = 4,
    parameter int SLOTS   = 4,
    parameter int CLK_KHZ = 5000,
    parameter int TMO_US  = 16,
    parameter int HOLD_NS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [2:0]       cpu_sel,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             bus_grant,
    input  logic             bus_reply,
    input  logic [DW-1:0]    bus_rdata,
    output logic             bus_req,
    output logic             addr_valid,
    output logic [DW+XW-1:0] bus_addr,
    output logic             bus_dir_out,
    output logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    data_in,
    output logic             busy,
    output logic             holdoff,
    output logic             err
);
    localparam int AW       = DW + XW;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int TMO_CYC  = TMO_US * CLK_KHZ / 1000;
    localparam int HOLD_CYC = (HOLD_NS * CLK_KHZ + 999999) / 1000000;

    logic          ctl_wr, start, err_clr, cap, dout_lock;
    logic [AW-1:0] out_addr, in_addr, addr_pick;

    assign ctl_wr    = cpu_we && (cpu_sel == SEL_CTRL);
    assign start     = ctl_wr && !cpu_wdata[CTL_NOGO_BIT];
    assign err_clr   = ctl_wr && cpu_wdata[CTL_NOGO_BIT] && cpu_wdata[CTL_CLR_BIT];
    assign addr_pick = cpu_wdata[CTL_DIR_BIT] ? out_addr : in_addr;
    assign dout_lock = holdoff || (busy && bus_dir_out);

    xe_regs #(.DW(DW), .XW(XW), .SLOTS(SLOTS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cpu_we),
        .sel      (cpu_sel),
        .wdata    (cpu_wdata),
        .dout_lock(dout_lock),
        .cap      (cap),
        .rdata    (bus_rdata),
        .slot_sel (cpu_wdata[CTL_SLOT_LSB +: SLOT_W]),
        .out_addr (out_addr),
        .in_addr  (in_addr),
        .dout     (bus_wdata),
        .din      (data_in)
    );

    xe_seq #(.AW(AW), .TMO_CYC(TMO_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .err_clr   (err_clr),
        .dir_in    (cpu_wdata[CTL_DIR_BIT]),
        .addr_in   (addr_pick),
        .bus_grant (bus_grant),
        .bus_reply (bus_reply),
        .bus_req   (bus_req),
        .addr_valid(addr_valid),
        .busy      (busy),
        .holdoff   (holdoff),
        .err       (err),
        .cap       (cap),
        .dir_q     (bus_dir_out),
        .addr_q    (bus_addr)
    );
endmodule

// File: rtl/xe_chk.sv
module xe_chk #(
    parameter int DW      = 16,
    parameter int CLK_KHZ = 5000,
    parameter int TMO_US  = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          bus_req,
    input logic          addr_valid,
    input logic          bus_reply,
    input logic          err,
    input logic          holdoff,
    input logic [DW-1:0] bus_wdata
);
    localparam int TMO_CYC = TMO_US * CLK_KHZ / 1000;

    logic        rq, seen_addr;
    logic [31:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq        <= 1'b0;
            seen_addr <= 1'b0;
            run_cnt   <= '0;
        end else begin
            rq <= bus_reply;
            if (!bus_req)        seen_addr <= 1'b0;
            else if (addr_valid) seen_addr <= 1'b1;
            run_cnt <= busy ? run_cnt + 1 : '0;
        end
    end

    assert_req_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);
    assert_addr_with_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> bus_req);
    assert_addr_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid);
    assert_reply_drops_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_addr && !addr_valid && bus_req && bus_reply && !rq) |=> !bus_req);
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && !bus_req));
    assert_watchdog_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < TMO_CYC));
    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        holdoff |-> $stable(bus_wdata));
endmodule

bind xfer_engine xe_chk #(.DW(DW), .CLK_KHZ(CLK_KHZ), .TMO_US(TMO_US)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .bus_req   (bus_req),
    .addr_valid(addr_valid),
    .bus_reply (bus_reply),
    .err       (err),
    .holdoff   (holdoff),
    .bus_wdata (bus_wdata)
);

// File: tb/xfer_engine_tb.sv
module xfer_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [2:0]  cpu_sel = '0;
    logic [15:0] cpu_wdata = '0;
    logic        bus_grant = 1'b0;
    logic        bus_reply = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        bus_req, addr_valid, bus_dir_out, busy, holdoff, err;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata, data_in;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .bus_grant(bus_grant), .bus_reply(bus_reply),
        .bus_rdata(bus_rdata), .bus_req(bus_req), .addr_valid(addr_valid),
        .bus_addr(bus_addr), .bus_dir_out(bus_dir_out), .bus_wdata(bus_wdata),
        .data_in(data_in), .busy(busy), .holdoff(holdoff), .err(err)
    );

    localparam int NV = 4;
    localparam logic        V_DIR  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [1:0]  V_SLOT [NV] = '{2'd0, 2'd1, 2'd3, 2'd2};
    localparam logic [3:0]  V_NIB  [NV] = '{4'hA, 4'h3, 4'hF, 4'h0};
    localparam logic [15:0] V_LO   [NV] = '{16'h1234, 16'h0F0E, 16'hFFFE, 16'h8000};
    localparam logic [15:0] V_DAT  [NV] = '{16'hBEEF, 16'h5A5A, 16'h0001, 16'hC3C3};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [2:0] s, input logic [15:0] d);
        cpu_we = 1'b1; cpu_sel = s; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 req", bus_req, 0);
        chk("R1 strobe/hold/err", {addr_valid, holdoff, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            cpu_wr(V_DIR[i] ? 3'd4 : 3'd5, {10'd0, V_SLOT[i], V_NIB[i]});
            cpu_wr(V_DIR[i] ? 3'd0 : 3'd1, V_LO[i]);
            if (V_DIR[i]) cpu_wr(3'd2, V_DAT[i]);
            cpu_wr(3'd3, {10'd0, V_SLOT[i], 3'd0, V_DIR[i]});
            chk("R2 start busy", busy, 1);
            chk("R4 req held", {bus_req, addr_valid}, 2'b10);
            @(negedge clk);
            chk("R4 still waiting for grant", {bus_req, addr_valid}, 2'b10);
            bus_grant = 1'b1;
            @(negedge clk);
            bus_grant = 1'b0;
            chk("R4 address phase", {bus_req, addr_valid}, 2'b11);
            chk("R3 address", bus_addr, {V_NIB[i], V_LO[i]});
            chk("R2 direction", bus_dir_out, V_DIR[i]);
            if (V_DIR[i]) chk("R3 outgoing word", bus_wdata, V_DAT[i]);
            @(negedge clk);
            chk("R4 one-cycle strobe", {bus_req, addr_valid}, 2'b10);
            bus_reply = 1'b1; bus_rdata = V_DAT[i];
            @(negedge clk);
            chk("R5 req dropped", bus_req, 0);
            chk("R6 busy while reply high", busy, 1);
            @(negedge clk);
            chk("R5 no second request", bus_req, 0);
            bus_reply = 1'b0;
            @(negedge clk);
            chk("R6 busy cleared", busy, 0);
            bus_rdata = 16'h0000;
            if (!V_DIR[i]) begin
                chk("R7 data_in", data_in, V_DAT[i]);
            end else begin
                chk("R8 holdoff active", holdoff, 1);
                cpu_wr(3'd2, 16'h0BAD);
                chk("R8 write ignored", bus_wdata, V_DAT[i]);
                chk("R8 holdoff ended", holdoff, 0);
            end
        end

        // R2: control write with bit6 set does not start
        cpu_wr(3'd3, 16'h0041);
        chk("R2 bit6 no start", {busy, bus_req}, 0);

        // R9/R11: timeout with a second start attempt mid-transfer
        cpu_wr(3'd0, 16'h2222);
        cpu_wr(3'd2, 16'h7777);
        cpu_wr(3'd3, 16'h0001);
        cpu_wr(3'd2, 16'h9999);
        chk("R8 write ignored while output busy", bus_wdata, 16'h7777);
        cpu_wr(3'd3, 16'h0000);
        chk("R11 direction kept", bus_dir_out, 1);
        for (int n = 2; n < 79; n++) @(negedge clk);
        chk("R9 busy before limit", busy, 1);
        @(negedge clk);
        chk("R9 aborted", {busy, bus_req}, 0);
        chk("R9 err set", err, 1);
        cpu_wr(3'd3, 16'h0040);
        chk("R10 err sticky", err, 1);
        cpu_wr(3'd3, 16'h0048);
        chk("R10 err cleared", err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule